// File: doc/BRIEF.md
# Probe-Word Memory Test Harness

This block lets a host exercise a set of small on-chip memories through one 128-bit parallel probe word. The host toggles a clock bit in the word. Each rising edge of that bit can do three things: capture a command packet from the low 112 bits, start an access on the memory named in the packet, or fold read results back into the packet. The packet register drives the low 112 bits of the output word, and the top 16 input bits are echoed above it. The host therefore reads results on the same lines it used to send commands.

A read takes four harness-clock edges. The first loads the packet, the second accesses the memory with the global enable set, the third is a plain edge that moves the memory outputs into data-out flip-flops, and the fourth raises the readback strobe so the captured words replace both data-in fields. Memory slots 0 to 4 hold dual-port models: port 0 reads and writes, and port 1 only reads. Slots 8 to 11 hold single-port models that use port 0 alone. All other slots are empty.

Top module: `sram_probe_harness`

## Requirements
- R1: Reset (probe bit 126, active high, synchronous to the harness clock at bit 127) clears the packet register, the data-out flip-flops, memory outputs and memory contents. After a reset edge, output bits 111:0 read 0.
- R2: Output bits 127:112 always equal input bits 127:112.
- R3: An edge with the input-load strobe (bit 125) high and the readback strobe low copies input bits 111:0 into the packet register.
- R4: An edge with both strobes low leaves output bits 111:0 unchanged.
- R5: With the global enable (bit 123) low, no memory is read or written.
- R6: The packet layout from bit 111 down is: selector 4, port-0 address 16, port-0 data 32, port-0 select (active low), port-0 write-enable (active low), port-0 mask 4, then the port-1 fields in the same order, ending at bit 0. A write needs the enable high and port-0 select and write-enable both low. Mask bit i gates data bits 8i+7:8i, and only the low 4 address bits index a 16-word memory.
- R7: The enable edge reads into the memory output. The next edge loads the data-out flip-flops. An edge with the readback strobe (bit 124) high then puts the port-0 and port-1 results into data bits 91:60 and 37:6. Before that edge the data fields keep their loaded value.
- R8: On dual-port slots 0 to 4, port 1 reads when its select is low and never writes, whatever its write-enable says.
- R9: Single-port slots 8 to 11 use only the port-0 fields, and their port-1 result is 0.
- R10: Empty slots (5 to 7, 12 to 15) store nothing and return 0 on both ports.
- R11: When both strobes are high on one edge, the data fields take the read results and every other field takes the input word.
- R12: An access with port-0 select high neither writes nor changes the port-0 result, which keeps the last value read.
- R13: A word never written since reset reads 0, and each slot keeps its own contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| probeIn | input | 128 | Host word: clock, reset, strobes, enable, spare bits and command packet |
| probeOut | output | 128 | Echo of bits 127:112 above the current packet register |

## Verification
Every cycle, the assertions check the echo of the upper bits and the reset clearing. They also check that the packet is captured under the input-load strobe, that it holds when neither strobe is set, and that the non-data fields follow the input when both strobes are high. Memory contents, byte masking, port-1 behaviour, empty slots and the four-edge readback timing can only be shown by the bench. It drives write and read sequences and compares the output word with its own memory model at every edge.

// File: rtl/harness_pkg.sv
package harness_pkg;
  localparam int PROBE_W = 128;
  localparam int SEL_W   = 4;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 32;
  localparam int MASK_W  = DATA_W / 8;

  localparam int CLK_BIT   = 127;
  localparam int RST_BIT   = 126;
  localparam int LDIN_BIT  = 125;
  localparam int LDMEM_BIT = 124;
  localparam int EN_BIT    = 123;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [ADDR_W-1:0] addr0;
    logic [DATA_W-1:0] din0;
    logic              csb0;
    logic              web0;
    logic [MASK_W-1:0] mask0;
    logic [ADDR_W-1:0] addr1;
    logic [DATA_W-1:0] din1;
    logic              csb1;
    logic              web1;
    logic [MASK_W-1:0] mask1;
  } cmdPkt_t;

  localparam int PKT_W = $bits(cmdPkt_t);

  typedef struct packed {
    logic rst;
    logic loadIn;
    logic loadMem;
    logic access;
  } strobes_t;
endpackage

// File: rtl/harness_ctrl.sv
module harness_ctrl
  import harness_pkg::*;
(
  input  logic [PROBE_W-1:EN_BIT] ctlBits,
  output logic                    harnessClk,
  output strobes_t                stb
);
  always_comb begin
    harnessClk  = ctlBits[CLK_BIT];
    stb.rst     = ctlBits[RST_BIT];
    stb.loadIn  = ctlBits[LDIN_BIT];
    stb.loadMem = ctlBits[LDMEM_BIT];
    stb.access  = ctlBits[EN_BIT];
  end
endmodule

// File: rtl/sram_model.sv
module sram_model
  import harness_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter bit DUAL  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              csb0,
  input  logic              web0,
  input  logic [ADDR_W-1:0] addr0,
  input  logic [DATA_W-1:0] din0,
  input  logic [MASK_W-1:0] mask0,
  input  logic              csb1,
  input  logic [ADDR_W-1:0] addr1,
  output logic [DATA_W-1:0] dout0,
  output logic [DATA_W-1:0] dout1
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  idx0, idx1;
  logic              unusedBits;

  assign idx0 = addr0[IDX_W-1:0];
  assign idx1 = addr1[IDX_W-1:0];
  assign unusedBits = ^{addr0[ADDR_W-1:IDX_W], addr1, csb1};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      dout0 <= '0;
      dout1 <= '0;
    end else if (en) begin
      if (!csb0) begin
        if (!web0) begin
          for (int b = 0; b < MASK_W; b++)
            if (mask0[b]) mem[idx0][8*b +: 8] <= din0[8*b +: 8];
        end else begin
          dout0 <= mem[idx0];
        end
      end
      if (DUAL && !csb1) dout1 <= mem[idx1];
    end
  end
endmodule

// File: rtl/harness_datapath.sv
module harness_datapath
  import harness_pkg::*;
#(
  parameter int DP_COUNT = 5,
  parameter int SP_BASE  = 8,
  parameter int SP_COUNT = 4,
  parameter int DEPTH    = 16
) (
  input  logic     clk,
  input  strobes_t stb,
  input  cmdPkt_t  pktIn,
  output cmdPkt_t  pktQ
);
  localparam int NUM_SLOTS = 1 << SEL_W;

  logic [NUM_SLOTS-1:0][DATA_W-1:0] rd0, rd1;
  logic [DATA_W-1:0] dout0Q, dout1Q;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic slotEn;
    assign slotEn = stb.access && (pktQ.sel == SEL_W'(s));
    if (s < DP_COUNT || (s >= SP_BASE && s < SP_BASE + SP_COUNT)) begin : g_mem
      sram_model #(.DEPTH(DEPTH), .DUAL(s < DP_COUNT)) u_mem (
        .clk  (clk),
        .rst  (stb.rst),
        .en   (slotEn),
        .csb0 (pktQ.csb0),
        .web0 (pktQ.web0),
        .addr0(pktQ.addr0),
        .din0 (pktQ.din0),
        .mask0(pktQ.mask0),
        .csb1 (pktQ.csb1),
        .addr1(pktQ.addr1),
        .dout0(rd0[s]),
        .dout1(rd1[s])
      );
    end else begin : g_empty
      logic unusedEn;
      assign unusedEn = slotEn;
      assign rd0[s] = '0;
      assign rd1[s] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.rst) begin
      dout0Q <= '0;
      dout1Q <= '0;
    end else begin
      dout0Q <= rd0[pktQ.sel];
      dout1Q <= rd1[pktQ.sel];
    end
  end

  always_ff @(posedge clk) begin
    if (stb.rst) begin
      pktQ <= '0;
    end else begin
      if (stb.loadIn) pktQ <= pktIn;
      if (stb.loadMem) begin
        pktQ.din0 <= dout0Q;
        pktQ.din1 <= dout1Q;
      end
    end
  end
endmodule

// File: rtl/sram_probe_harness.sv
module sram_probe_harness
  import harness_pkg::*;
#(
  parameter int DP_COUNT = 5,
  parameter int SP_BASE  = 8,
  parameter int SP_COUNT = 4,
  parameter int DEPTH    = 16
) (
  input  logic [127:0] probeIn,
  output logic [127:0] probeOut
);
  logic     harnessClk;
  strobes_t stb;
  cmdPkt_t  pktQ;

  harness_ctrl u_ctrl (
    .ctlBits   (probeIn[PROBE_W-1:EN_BIT]),
    .harnessClk(harnessClk),
    .stb       (stb)
  );

  harness_datapath #(
    .DP_COUNT(DP_COUNT), .SP_BASE(SP_BASE), .SP_COUNT(SP_COUNT), .DEPTH(DEPTH)
  ) u_dp (
    .clk  (harnessClk),
    .stb  (stb),
    .pktIn(cmdPkt_t'(probeIn[PKT_W-1:0])),
    .pktQ (pktQ)
  );

  assign probeOut = {probeIn[PROBE_W-1:PKT_W], pktQ};
endmodule

// File: rtl/harness_checker.sv
module harness_checker
  import harness_pkg::*;
(
  input logic [127:0] probeIn,
  input logic [127:0] probeOut
);
  logic    hClk, rst, ldIn, ldMem;
  cmdPkt_t inPkt, outPkt;

  assign hClk   = probeIn[CLK_BIT];
  assign rst    = probeIn[RST_BIT];
  assign ldIn   = probeIn[LDIN_BIT];
  assign ldMem  = probeIn[LDMEM_BIT];
  assign inPkt  = cmdPkt_t'(probeIn[PKT_W-1:0]);
  assign outPkt = cmdPkt_t'(probeOut[PKT_W-1:0]);

  a_r1_reset_clears: assert property (@(posedge hClk) disable iff (rst)
    $past(rst) |-> probeOut[PKT_W-1:0] == '0);

  a_r2_upper_echo: assert property (@(posedge hClk) disable iff (rst)
    probeOut[PROBE_W-1:PKT_W] == probeIn[PROBE_W-1:PKT_W]);

  a_r3_input_capture: assert property (@(posedge hClk) disable iff (rst)
    (ldIn && !ldMem) |=> probeOut[PKT_W-1:0] == $past(probeIn[PKT_W-1:0]));

  a_r4_packet_holds: assert property (@(posedge hClk) disable iff (rst)
    (!ldIn && !ldMem) |=> $stable(probeOut[PKT_W-1:0]));

  a_r11_ctrl_fields_from_input: assert property (@(posedge hClk) disable iff (rst)
    (ldIn && ldMem) |=> (outPkt.addr0 == $past(inPkt.addr0)) && (outPkt.sel == $past(inPkt.sel))
                        && (outPkt.mask1 == $past(inPkt.mask1)));
endmodule

bind sram_probe_harness harness_checker u_chk (.probeIn(probeIn), .probeOut(probeOut));

// File: tb/sram_probe_harness_bench.sv
`timescale 1ns/1ps
module sram_probe_harness_bench;
  logic clk = 1'b0;
  logic rstB = 1'b0, ldIn = 1'b0, ldMem = 1'b0, gcsB = 1'b0;
  logic [10:0]  spare = '0;
  logic [111:0] pktIn = '0;
  logic [127:0] probeIn, probeOut;
  int nCmp = 0, nBad = 0;
  string curReq = "R1";
  bit modelLive = 1'b0;

  always #2.5 clk = ~clk;
  assign probeIn = {clk, rstB, ldIn, ldMem, gcsB, spare, pktIn};

  sram_probe_harness u_sram_probe_harness (.probeIn(probeIn), .probeOut(probeOut));

  // reference model state
  logic [31:0] mMem [16][16];
  logic [31:0] mOut0 [16];
  logic [31:0] mOut1 [16];
  logic [111:0] mPkt;
  logic [31:0] mDout0, mDout1;

  function automatic bit isDual(input int s);   return s < 5; endfunction
  function automatic bit isSingle(input int s); return s >= 8 && s < 12; endfunction

  function automatic logic [111:0] mkPkt(input logic [3:0] sel, input logic [15:0] a0,
      input logic [31:0] d0, input logic c0, input logic w0, input logic [3:0] m0,
      input logic [15:0] a1, input logic [31:0] d1, input logic c1, input logic w1,
      input logic [3:0] m1);
    return {sel, a0, d0, c0, w0, m0, a1, d1, c1, w1, m1};
  endfunction

  always @(posedge clk) begin : model
    int s;
    logic [3:0] a0, a1;
    logic [31:0] nd0, nd1;
    if (rstB) begin
      for (int i = 0; i < 16; i++) begin
        mOut0[i] = '0; mOut1[i] = '0;
        for (int j = 0; j < 16; j++) mMem[i][j] = '0;
      end
      mPkt = '0; mDout0 = '0; mDout1 = '0;
      modelLive = 1'b1;
    end else if (modelLive) begin
      s = int'(mPkt[111:108]);
      nd0 = mOut0[s]; nd1 = mOut1[s];
      a0 = mPkt[95:92]; a1 = mPkt[41:38];
      if (gcsB && (isDual(s) || isSingle(s))) begin
        if (isDual(s) && !mPkt[5]) mOut1[s] = mMem[s][a1];
        if (!mPkt[59]) begin
          if (!mPkt[58]) begin
            for (int b = 0; b < 4; b++)
              if (mPkt[54+b]) mMem[s][a0][8*b +: 8] = mPkt[60+8*b +: 8];
          end else mOut0[s] = mMem[s][a0];
        end
      end
      if (ldIn) mPkt = pktIn;
      if (ldMem) begin mPkt[91:60] = mDout0; mPkt[37:6] = mDout1; end
      mDout0 = nd0; mDout1 = nd1;
    end
  end

  always @(negedge clk) begin
    if (modelLive) begin
      nCmp++;
      if (probeOut !== {probeIn[127:112], mPkt}) begin
        nBad++;
        $display("FAIL %s model compare: actual %h expected %h", curReq, probeOut,
                 {probeIn[127:112], mPkt});
      end
    end
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic li, input logic lm, input logic g,
                     input logic [111:0] p);
    @(negedge clk); #1;
    rstB = r; ldIn = li; ldMem = lm; gcsB = g; pktIn = p;
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] sel, input logic [15:0] a, input logic [31:0] d,
                    input logic [3:0] m);
    logic [111:0] p;
    p = mkPkt(sel, a, d, 1'b0, 1'b0, m, 16'h0, 32'h0, 1'b1, 1'b1, 4'h0);
    cyc(0, 1, 0, 0, p);
    cyc(0, 0, 0, 1, p);
  endtask

  task automatic rd(input logic [3:0] sel, input logic [15:0] a0, input logic [15:0] a1,
                    input logic useP1, output logic [31:0] d0, output logic [31:0] d1);
    logic [111:0] p;
    p = mkPkt(sel, a0, 32'h0, 1'b0, 1'b1, 4'h0, a1, 32'h0, !useP1, 1'b1, 4'h0);
    cyc(0, 1, 0, 0, p);
    cyc(0, 0, 0, 1, p);
    cyc(0, 0, 0, 0, p);
    cyc(0, 0, 1, 0, p);
    d0 = probeOut[91:60]; d1 = probeOut[37:6];
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    logic [111:0] pA, pB;
    logic [31:0] d0, d1;
    cyc(1, 0, 0, 0, '0);
    cyc(1, 1, 1, 1, {112{1'b1}});
    curReq = "R1";
    check("R1 reset clears packet", {16'h0, probeOut[111:0]}, 128'h0);

    curReq = "R2"; spare = 11'h5A5;
    cyc(0, 0, 0, 0, '0);
    check("R2 upper echo", {112'h0, probeOut[127:112]}, {112'h0, probeIn[127:112]});

    curReq = "R3";
    pA = mkPkt(4'h3, 16'hBEEF, 32'hCAFEF00D, 1'b1, 1'b1, 4'h9, 16'h1234, 32'h0BADC0DE,
               1'b1, 1'b0, 4'h6);
    cyc(0, 1, 0, 0, pA);
    check("R3 input capture", {16'h0, probeOut[111:0]}, {16'h0, pA});

    curReq = "R4";
    cyc(0, 0, 0, 0, ~pA);
    cyc(0, 0, 0, 1, ~pA);
    check("R4 packet holds", {16'h0, probeOut[111:0]}, {16'h0, pA});

    curReq = "R13";
    rd(4'd3, 16'd9, 16'd0, 1'b0, d0, d1);
    check("R13 unwritten word", {96'h0, d0}, 128'h0);

    curReq = "R6";
    wr(4'd0, 16'd1, 32'h11223344, 4'hF);
    rd(4'd0, 16'd1, 16'd0, 1'b0, d0, d1);
    check("R6 full write", {96'h0, d0}, {96'h0, 32'h11223344});
    wr(4'd0, 16'h0011, 32'hAABBCCDD, 4'b0101);
    rd(4'd0, 16'd1, 16'd0, 1'b0, d0, d1);
    check("R6 byte mask and low address bits", {96'h0, d0}, {96'h0, 32'h11BB33DD});

    curReq = "R13";
    rd(4'd4, 16'd1, 16'd0, 1'b0, d0, d1);
    check("R13 slots independent", {96'h0, d0}, 128'h0);

    curReq = "R5";
    pB = mkPkt(4'd2, 16'd4, 32'hFFFFFFFF, 1'b0, 1'b0, 4'hF, 16'h0, 32'h0, 1'b1, 1'b1, 4'h0);
    cyc(0, 1, 0, 0, pB);
    cyc(0, 0, 0, 0, pB);
    cyc(0, 0, 0, 0, pB);
    rd(4'd2, 16'd4, 16'd0, 1'b0, d0, d1);
    check("R5 no write with enable low", {96'h0, d0}, 128'h0);

    curReq = "R7";
    wr(4'd0, 16'd5, 32'h600DCAFE, 4'hF);
    pB = mkPkt(4'd0, 16'd5, 32'h5A5A5A5A, 1'b0, 1'b1, 4'h0, 16'h0, 32'h0, 1'b1, 1'b1, 4'h0);
    cyc(0, 1, 0, 0, pB);
    cyc(0, 0, 0, 1, pB);
    cyc(0, 0, 0, 0, pB);
    check("R7 data held before readback", {96'h0, probeOut[91:60]}, {96'h0, 32'h5A5A5A5A});
    cyc(0, 0, 1, 0, pB);
    check("R7 data after readback", {96'h0, probeOut[91:60]}, {96'h0, 32'h600DCAFE});

    curReq = "R8";
    wr(4'd1, 16'd2, 32'h00000022, 4'hF);
    wr(4'd1, 16'd1, 32'h00000005, 4'hF);
    rd(4'd1, 16'd2, 16'd1, 1'b1, d0, d1);
    check("R8 port0 read", {96'h0, d0}, {96'h0, 32'h22});
    check("R8 port1 read", {96'h0, d1}, {96'h0, 32'h5});
    pB = mkPkt(4'd1, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0, 16'd3, 32'hFFFFFFFF, 1'b0, 1'b0, 4'hF);
    cyc(0, 1, 0, 0, pB);
    cyc(0, 0, 0, 1, pB);
    rd(4'd1, 16'd3, 16'd3, 1'b1, d0, d1);
    check("R8 port1 write ignored", {64'h0, d0, d1}, 128'h0);

    curReq = "R9";
    wr(4'd8, 16'd1, 32'hDEADBEEF, 4'hF);
    rd(4'd8, 16'd1, 16'd1, 1'b1, d0, d1);
    check("R9 single-port data", {96'h0, d0}, {96'h0, 32'hDEADBEEF});
    check("R9 single-port port1 zero", {96'h0, d1}, 128'h0);
    wr(4'd11, 16'd6, 32'h0F0F1234, 4'hF);
    rd(4'd11, 16'd6, 16'd6, 1'b1, d0, d1);
    check("R9 last single-port slot", {64'h0, d0, d1}, {64'h0, 32'h0F0F1234, 32'h0});

    curReq = "R10";
    wr(4'd6, 16'd1, 32'h12345678, 4'hF);
    rd(4'd6, 16'd1, 16'd1, 1'b1, d0, d1);
    check("R10 empty slot 6", {64'h0, d0, d1}, 128'h0);
    wr(4'd12, 16'd1, 32'h12345678, 4'hF);
    rd(4'd12, 16'd1, 16'd1, 1'b1, d0, d1);
    check("R10 empty slot 12", {64'h0, d0, d1}, 128'h0);

    curReq = "R11";
    pB = mkPkt(4'd0, 16'd1, 32'h0, 1'b0, 1'b1, 4'h0, 16'h0, 32'h0, 1'b1, 1'b1, 4'h0);
    cyc(0, 1, 0, 0, pB);
    cyc(0, 0, 0, 1, pB);
    cyc(0, 0, 0, 0, pB);
    pA = mkPkt(4'd0, 16'hABCD, 32'h00001234, 1'b1, 1'b1, 4'h0, 16'h0, 32'h0, 1'b1, 1'b1, 4'h0);
    cyc(0, 1, 1, 0, pA);
    check("R11 data from readback", {96'h0, probeOut[91:60]}, {96'h0, 32'h11BB33DD});
    check("R11 address from input", {112'h0, probeOut[107:92]}, {112'h0, 16'hABCD});

    curReq = "R12";
    wr(4'd0, 16'd7, 32'h77777777, 4'hF);
    rd(4'd0, 16'd7, 16'd0, 1'b0, d0, d1);
    pB = mkPkt(4'd0, 16'd7, 32'h0, 1'b1, 1'b0, 4'hF, 16'h0, 32'h0, 1'b1, 1'b1, 4'h0);
    cyc(0, 1, 0, 0, pB);
    cyc(0, 0, 0, 1, pB);
    pB = mkPkt(4'd0, 16'd1, 32'h0, 1'b1, 1'b1, 4'h0, 16'h0, 32'h0, 1'b1, 1'b1, 4'h0);
    cyc(0, 1, 0, 0, pB);
    cyc(0, 0, 0, 1, pB);
    cyc(0, 0, 0, 0, pB);
    cyc(0, 0, 1, 0, pB);
    check("R12 result held with select high", {96'h0, probeOut[91:60]}, {96'h0, 32'h77777777});
    rd(4'd0, 16'd7, 16'd0, 1'b0, d0, d1);
    check("R12 no write with select high", {96'h0, d0}, {96'h0, 32'h77777777});

    curReq = "R1";
    cyc(1, 0, 0, 0, '0);
    rd(4'd0, 16'd7, 16'd0, 1'b0, d0, d1);
    check("R1 reset clears memory", {96'h0, d0}, 128'h0);

    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule